// File: doc/BRIEF.md
# Accumulator Datapath ALU with Shift, Rotate and Skip Tests

This block is the purely combinational arithmetic and logic unit of a small accumulator machine with 16-bit words. The surrounding control logic picks an operation code. It also supplies operand A, which is the accumulator or a chosen register, operand B, which is a memory word or a register, and a 4-bit shift count. The ALU returns a 16-bit result in the same evaluation. Word arithmetic wraps silently. There is no carry, overflow or status register.

Three test operations drive a single `skip` output. When `skip` is high, the sequencer advances its instruction counter one extra step and so jumps over the next instruction. Subtraction is not a native operation. Software builds it by complementing an operand and then incrementing it.

The block holds no state, so it has no clock, reset or state machine. Operation decoding is one `unique case` over an enumerated operation type. The shift and rotate paths come from a single parameterised barrel structure that is instantiated once per variant.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_sel` are: 0 add, 1 increment, 2 decrement, 3 AND, 4 OR, 5 NOT, 6 shift right, 7 shift left, 8 rotate left, 9 LSB test, 10 nonzero test, 11 negative test. With code 0, `result` is (A + B) modulo 2^16, and no carry is reported.
- R2: Code 1 gives A + 1 and code 2 gives A - 1, both wrapping modulo 2^16 (FFFF+1 = 0000, 0000-1 = FFFF).
- R3: Code 3 gives A & B, code 4 gives A | B, and code 5 gives ~A, all bitwise over 16 bits.
- R4: Applying NOT (code 5) and then increment (code 1) to a value yields its two's-complement negation, including for 0000 and 8000.
- R5: Code 6 shifts A right by `shamt` (0 to 15). Bits leaving bit 0 are lost, and the vacated upper bits are zero.
- R6: Code 7 shifts A left by `shamt`. Bits leaving bit 15 are lost, and the vacated lower bits are zero.
- R7: Code 8 rotates A left by `shamt`. Bits leaving bit 15 re-enter at bit 0, so no bit is lost.
- R8: For codes 6, 7 and 8, a `shamt` of zero returns A unchanged.
- R9: Code 9 drives `skip` high exactly when bit 0 of A is 1.
- R10: Code 10 drives `skip` high exactly when A is not zero.
- R11: Code 11 drives `skip` high exactly when A is negative as a two's-complement number, i.e. bit 15 of A is 1.
- R12: `skip` is low for every code other than 9, 10 and 11. The test codes pass A through to `result` unchanged.
- R13: Codes 12 to 15 are unassigned. They drive `result` to 0000 and `skip` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see R1) |
| opnd_a | input | 16 | Operand A: accumulator or selected register |
| opnd_b | input | 16 | Operand B: memory word or register |
| shamt | input | 4 | Shift or rotate distance, 0 to 15 |
| result | output | 16 | Operation result |
| skip | output | 1 | Skip-next condition from the test codes |

## Verification
Immediate assertions watch the output on every input change. They check that `skip` never rises outside the three test codes and that increment and decrement differ from A by exactly one. They also check that rotation preserves the population count, that a left shift leaves its low bits clear, that a right shift never grows the value, and that zero-distance moves are identities. Exact results, such as the bit-for-bit rotate and shift patterns, the test outcomes and the NOT-then-increment negation sequence, can only be shown by the bench. It compares every result against its own bit-loop reference model, using random vectors and directed corner values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_INC   = 4'd1,
        OP_DEC   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_NOT   = 4'd5,
        OP_SHR   = 4'd6,
        OP_SHL   = 4'd7,
        OP_ROL   = 4'd8,
        OP_TLSB  = 4'd9,
        OP_TNZ   = 4'd10,
        OP_TNEG  = 4'd11,
        OP_RSV12 = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    typedef enum int {
        MV_SHR = 0,
        MV_SHL = 1,
        MV_ROL = 2
    } move_kind_e;

endpackage

// File: rtl/acc_alu_word.sv
// Wrapping arithmetic and bitwise logic on full words.
module acc_alu_word
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  res
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_INC:  res = a + ONE;
            OP_DEC:  res = a - ONE;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_barrel.sv
// Logarithmic barrel: stage s moves by 2**s when amt[s] is set.
module acc_alu_barrel
    import acc_alu_pkg::*;
#(
    parameter int         W    = 16,
    parameter move_kind_e KIND = MV_SHR
) (
    input  logic [W-1:0]          din,
    input  logic [$clog2(W)-1:0]  amt,
    output logic [W-1:0]          dout
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] stg [0:STAGES];

    assign stg[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int D = 1 << s;
        if (KIND == MV_SHR) begin : g_shr
            assign stg[s+1] = amt[s] ? (stg[s] >> D) : stg[s];
        end else if (KIND == MV_SHL) begin : g_shl
            assign stg[s+1] = amt[s] ? (stg[s] << D) : stg[s];
        end else begin : g_rol
            assign stg[s+1] = amt[s] ? ((stg[s] << D) | (stg[s] >> (W - D)))
                                     : stg[s];
        end
    end

    assign dout = stg[STAGES];
endmodule

// File: rtl/acc_alu_cond.sv
// Skip-condition tests on operand A.
module acc_alu_cond
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    output logic          hit
);
    always_comb begin
        unique case (op)
            OP_TLSB: hit = a[0];
            OP_TNZ:  hit = |a;
            OP_TNEG: hit = a[W-1];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [3:0]          op_sel,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [DATA_W-1:0]   result,
    output logic                skip
);
    alu_op_e          op;
    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] shr_res;
    logic [DATA_W-1:0] shl_res;
    logic [DATA_W-1:0] rol_res;
    logic              cond_hit;

    assign op = alu_op_e'(op_sel);

    acc_alu_word #(.W(DATA_W)) u_word (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (word_res)
    );

    acc_alu_barrel #(.W(DATA_W), .KIND(MV_SHR)) u_shr (
        .din (opnd_a), .amt (shamt), .dout (shr_res)
    );
    acc_alu_barrel #(.W(DATA_W), .KIND(MV_SHL)) u_shl (
        .din (opnd_a), .amt (shamt), .dout (shl_res)
    );
    acc_alu_barrel #(.W(DATA_W), .KIND(MV_ROL)) u_rol (
        .din (opnd_a), .amt (shamt), .dout (rol_res)
    );

    acc_alu_cond #(.W(DATA_W)) u_cond (
        .op  (op),
        .a   (opnd_a),
        .hit (cond_hit)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_INC, OP_DEC,
            OP_AND, OP_OR, OP_NOT:     result = word_res;
            OP_SHR:                    result = shr_res;
            OP_SHL:                    result = shl_res;
            OP_ROL:                    result = rol_res;
            OP_TLSB, OP_TNZ, OP_TNEG:  result = opnd_a;
            default:                   result = '0;
        endcase
    end

    assign skip = cond_hit;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input logic [3:0]    op_sel,
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [SW-1:0] shamt,
    input logic [W-1:0]  result,
    input logic          skip
);
    logic [W-1:0] low_mask;
    assign low_mask = W'((1 << shamt) - 1);

    always_comb begin
        if (op_sel != OP_TLSB && op_sel != OP_TNZ && op_sel != OP_TNEG)
            a_r12_skip_only_tests: assert (!skip)
                else $error("R12 skip high for op %0d", op_sel);
        if (op_sel == OP_INC)
            a_r2_inc_step: assert (W'(result - opnd_a) == W'(1))
                else $error("R2 increment step");
        if (op_sel == OP_DEC)
            a_r2_dec_step: assert (W'(opnd_a - result) == W'(1))
                else $error("R2 decrement step");
        if (op_sel == OP_ROL)
            a_r7_rol_keeps_ones: assert ($countones(result) == $countones(opnd_a))
                else $error("R7 rotate lost bits");
        if (op_sel == OP_SHL)
            a_r6_shl_low_clear: assert ((result & low_mask) == '0)
                else $error("R6 low bits not clear");
        if (op_sel == OP_SHR)
            a_r5_shr_not_larger: assert (result <= opnd_a)
                else $error("R5 right shift grew value");
        if ((op_sel == OP_SHR || op_sel == OP_SHL || op_sel == OP_ROL) && shamt == '0)
            a_r8_zero_identity: assert (result == opnd_a)
                else $error("R8 zero move changed operand");
        if (op_sel >= 4'd12)
            a_r13_unused_zero: assert (result == '0)
                else $error("R13 unused code nonzero");
    end
endmodule

bind acc_alu acc_alu_chk #(.W(DATA_W), .SW(SHAMT_W)) u_chk (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .result (result),
    .skip   (skip)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [3:0]  shamt = 4'd0;
    logic [15:0] result;
    logic        skip;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .result (result),
        .skip   (skip)
    );

    function automatic logic [15:0] model_res(input logic [3:0] op, input logic [15:0] a,
                                              input logic [15:0] b, input logic [3:0] k);
        logic [15:0] r;
        r = 16'd0;
        case (op)
            4'd0: r = a + b;
            4'd1: r = a + 16'd1;
            4'd2: r = a - 16'd1;
            4'd3: for (int i = 0; i < 16; i++) r[i] = a[i] & b[i];
            4'd4: for (int i = 0; i < 16; i++) r[i] = a[i] | b[i];
            4'd5: for (int i = 0; i < 16; i++) r[i] = !a[i];
            4'd6: for (int i = 0; i < 16; i++) r[i] = (i + k < 16) ? a[i + k] : 1'b0;
            4'd7: for (int i = 0; i < 16; i++) r[i] = (i >= k) ? a[i - k] : 1'b0;
            4'd8: for (int i = 0; i < 16; i++) r[(i + k) % 16] = a[i];
            4'd9, 4'd10, 4'd11: r = a;
            default: r = 16'd0;
        endcase
        return r;
    endfunction

    function automatic logic model_skip(input logic [3:0] op, input logic [15:0] a);
        if (op == 4'd9)  return a[0];
        if (op == 4'd10) return a != 16'd0;
        if (op == 4'd11) return $signed(a) < 0;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [3:0] k);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = k;
        #2;
    endtask

    task automatic run(input string tag, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [3:0] k);
        apply(op, a, b, k);
        check({tag, " result"}, result, model_res(op, a, b, k));
        check({tag, " skip"}, {15'd0, skip}, {15'd0, model_skip(op, a)});
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] t;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state after reset: add of zeros
        apply(4'd0, 16'h0000, 16'h0000, 4'd0);
        check("R1 idle result", result, 16'h0000);
        check("R12 idle skip", {15'd0, skip}, 16'h0000);

        run("R1 add wrap", 4'd0, 16'hFFFF, 16'h0001, 4'd0);
        run("R1 add", 4'd0, 16'h0009, 16'h0005, 4'd0);
        run("R2 inc wrap", 4'd1, 16'hFFFF, 16'h1234, 4'd0);
        run("R2 dec wrap", 4'd2, 16'h0000, 16'h1234, 4'd0);
        run("R3 and", 4'd3, 16'hF0F0, 16'h3C3C, 4'd0);
        run("R3 or", 4'd4, 16'hF0F0, 16'h3C3C, 4'd0);
        run("R3 not", 4'd5, 16'hA5A5, 16'h0000, 4'd0);

        // R4: negation via NOT then INC
        foreach (t[i]) begin end
        apply(4'd5, 16'h0005, 16'h0, 4'd0); t = result;
        apply(4'd1, t, 16'h0, 4'd0);
        check("R4 neg 5", result, 16'hFFFB);
        apply(4'd5, 16'h8000, 16'h0, 4'd0); t = result;
        apply(4'd1, t, 16'h0, 4'd0);
        check("R4 neg 8000", result, 16'h8000);
        apply(4'd5, 16'h0000, 16'h0, 4'd0); t = result;
        apply(4'd1, t, 16'h0, 4'd0);
        check("R4 neg 0", result, 16'h0000);

        run("R5 shr 15", 4'd6, 16'h8001, 16'h0, 4'd15);
        run("R5 shr 4", 4'd6, 16'hABCD, 16'h0, 4'd4);
        run("R6 shl 15", 4'd7, 16'h8003, 16'h0, 4'd15);
        run("R6 shl 5", 4'd7, 16'hABCD, 16'h0, 4'd5);
        apply(4'd8, 16'h8001, 16'h0, 4'd1);
        check("R7 rol wrap", result, 16'h0003);
        run("R7 rol 12", 4'd8, 16'h1234, 16'h0, 4'd12);
        for (int m = 6; m <= 8; m++) begin
            apply(m[3:0], 16'hC3A5, 16'h0, 4'd0);
            check("R8 zero move", result, 16'hC3A5);
        end
        run("R9 lsb set", 4'd9, 16'h0001, 16'h0, 4'd0);
        run("R9 lsb clear", 4'd9, 16'hFFFE, 16'h0, 4'd0);
        run("R10 zero", 4'd10, 16'h0000, 16'h0, 4'd0);
        run("R10 nonzero", 4'd10, 16'h0100, 16'h0, 4'd0);
        run("R11 neg", 4'd11, 16'h8000, 16'h0, 4'd0);
        run("R11 pos", 4'd11, 16'h7FFF, 16'h0, 4'd0);
        run("R12 no skip on add", 4'd0, 16'hFFFF, 16'hFFFF, 4'd0);
        for (int c = 12; c < 16; c++)
            run("R13 unused", c[3:0], 16'hFFFF, 16'hFFFF, 4'd7);

        // Random mix across all codes
        for (int n = 0; n < 400; n++)
            run("R1 random", 4'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule